// File: doc/BRIEF.md
# Steerable Watchdog Timer

This block is a byte-programmed watchdog. One control byte holds a 5-bit multiplier, a 2-bit resolution exponent and a steering bit. Together the multiplier and exponent give a timeout measured in ticks of a 16 Hz enable input. Software keeps the watchdog alive in one of two ways: it rewrites the control byte, or it reads the flags byte. Either access restarts the countdown.

When the countdown runs out, the block sets an expiry flag. The steering bit then selects what happens next:
- **Steering bit set:** the block issues a one-cycle system reset request, clears the control byte and clears one bit of a general-purpose auxiliary byte.
- **Steering bit clear:** the block raises a one-cycle interrupt pulse and leaves the control byte as it was.

Registers are reached over a simple byte bus. A write strobe takes effect on the clock edge. Read data is combinational on the address.

Top module: `wdog_steer`

## Requirements
- R1: After reset, the flags, control and auxiliary bytes all read 0x00, and `rst_req` and `irq` are low.
- R2: The timeout is multiplier × 4^exponent ticks. The multiplier is control bits 6:2 and the exponent is control bits 1:0. After a reload, the pulse output is first seen high in the cycle that follows the edge carrying the final tick.
- R3: A write to the control byte (address 1) clears the expiry flag and restarts the countdown with the written value. A tick in that same cycle does not count.
- R4: A read of the flags byte (address 0) restarts the countdown from the current control value and leaves the expiry flag unchanged. A tick in that same cycle does not count.
- R5: On expiry the expiry flag is set. The flags byte then reads 0x80, because the flag is bit 7 and all other bits read 0.
- R6: On expiry with control bit 7 set, `rst_req` pulses for exactly one cycle, the control byte becomes 0x00 and bit 6 of the auxiliary byte is cleared.
- R7: On expiry with control bit 7 clear, `irq` pulses for exactly one cycle, the control byte keeps its value, and nothing further expires until the next reload.
- R8: A control value whose multiplier field is zero never produces an expiry, whatever the exponent and steering bit.
- R9: Bus writes to the flags byte have no effect on it.
- R10: Address map. Address 0 is the flags byte (read-only). Address 1 is the control byte. Address 2 is the auxiliary byte, which can be read and written. Address 3 reads 0x00 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_16hz | input | 1 | One-cycle enable, 16 per second |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (needed for the flags-read reload) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| rst_req | output | 1 | One-cycle system reset request |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The checker tests these properties on every cycle:
- both pulses last a single cycle and never occur together;
- any pulse comes with the expiry flag set, and the flag rises only together with a pulse;
- only a control write clears the flag, which covers the flags byte ignoring writes;
- a reset pulse leaves the control byte zero, and an interrupt pulse leaves a live, unsteered control value.

Only the bench scenarios can show the following:
- the exact tick count to expiry for different multiplier and exponent pairs;
- a flags read postponing an expiry that was about to happen;
- a zero multiplier staying silent over thousands of ticks;
- the auxiliary bit being cleared.

// File: rtl/wdog_steer_pkg.sv
package wdog_steer_pkg;
    localparam int ADDR_W    = 2;
    localparam int DATA_W    = 8;
    localparam int MULT_W    = 5;
    localparam int RES_W     = 2;
    localparam int MULT_LSB  = RES_W;
    localparam int STEER_BIT = 7;
    localparam int FLAG_BIT  = 7;
    localparam int AUX_BIT   = 6;

    typedef enum logic [ADDR_W-1:0] {
        REG_FLAGS = 2'd0,
        REG_CTRL  = 2'd1,
        REG_AUX   = 2'd2,
        REG_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic              flag;
        logic [DATA_W-1:0] aux;
        logic              rst_req;
        logic              irq;
    } wdog_state_t;
endpackage

// File: rtl/wdog_period_decode.sv
module wdog_period_decode #(
    parameter int MULT_W = 5,
    parameter int RES_W  = 2,
    parameter int CNT_W  = 11
) (
    input  logic [MULT_W-1:0] mult,
    input  logic [RES_W-1:0]  res,
    output logic [CNT_W-1:0]  period
);
    localparam int SH_W = RES_W + 1;

    logic [SH_W-1:0] shamt;

    always_comb begin
        shamt  = {res, 1'b0};
        period = CNT_W'(mult) << shamt;
    end
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        expire = 1'b0;
        if (load) begin
            cnt_d = load_val;
        end else if (tick && cnt_q != '0) begin
            cnt_d  = cnt_q - ONE;
            expire = (cnt_q == ONE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/wdog_steer.sv
module wdog_steer
    import wdog_steer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_16hz,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rst_req,
    output logic              irq
);
    localparam int CNT_W = MULT_W + 2 * ((1 << RES_W) - 1);

    wdog_state_t       st_d, st_q;
    logic              wr_ctrl, rd_flags, load, expire;
    logic [DATA_W-1:0] ctrl_src;
    logic [CNT_W-1:0]  period;
    logic [DATA_W-1:0] ctrl_q;
    logic              flag_q;

    assign wr_ctrl  = bus_wr && (reg_sel_e'(bus_addr) == REG_CTRL);
    assign rd_flags = bus_rd && (reg_sel_e'(bus_addr) == REG_FLAGS);
    assign load     = wr_ctrl || rd_flags;
    assign ctrl_src = wr_ctrl ? bus_wdata : st_q.ctrl;

    wdog_period_decode #(
        .MULT_W (MULT_W),
        .RES_W  (RES_W),
        .CNT_W  (CNT_W)
    ) u_decode (
        .mult   (ctrl_src[MULT_LSB +: MULT_W]),
        .res    (ctrl_src[RES_W-1:0]),
        .period (period)
    );

    wdog_countdown #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (period),
        .tick     (tick_16hz),
        .expire   (expire)
    );

    always_comb begin
        st_d         = st_q;
        st_d.rst_req = 1'b0;
        st_d.irq     = 1'b0;
        if (bus_wr) begin
            case (reg_sel_e'(bus_addr))
                REG_CTRL: begin
                    st_d.ctrl = bus_wdata;
                    st_d.flag = 1'b0;
                end
                REG_AUX:  st_d.aux = bus_wdata;
                default:  ;
            endcase
        end
        if (expire) begin
            st_d.flag = 1'b1;
            if (st_q.ctrl[STEER_BIT]) begin
                st_d.ctrl         = '0;
                st_d.aux[AUX_BIT] = 1'b0;
                st_d.rst_req      = 1'b1;
            end else begin
                st_d.irq = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (reg_sel_e'(bus_addr))
            REG_FLAGS: bus_rdata = DATA_W'({st_q.flag, FLAG_BIT'(0)});
            REG_CTRL:  bus_rdata = st_q.ctrl;
            REG_AUX:   bus_rdata = st_q.aux;
            default:   bus_rdata = '0;
        endcase
    end

    assign rst_req = st_q.rst_req;
    assign irq     = st_q.irq;
    assign ctrl_q  = st_q.ctrl;
    assign flag_q  = st_q.flag;
endmodule

// File: rtl/wdog_steer_chk.sv
module wdog_steer_chk
    import wdog_steer_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              rst_req,
    input logic              irq,
    input logic [DATA_W-1:0] ctrl_q,
    input logic              flag_q
);
    logic wr_ctrl;
    assign wr_ctrl = bus_wr && (reg_sel_e'(bus_addr) == REG_CTRL);

    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req); // R6
    AST_RST_CLEARS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> ctrl_q == '0); // R6
    AST_NO_DUAL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_req && irq)); // R6
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R7
    AST_IRQ_KEEPS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (!ctrl_q[STEER_BIT] && ctrl_q[MULT_LSB +: MULT_W] != '0)); // R8
    AST_PULSE_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req || irq) |-> flag_q); // R5
    AST_FLAG_RISE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> (rst_req || irq)); // R5
    AST_WR_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> !flag_q); // R3
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !wr_ctrl) |=> flag_q); // R9
endmodule

bind wdog_steer wdog_steer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .rst_req  (rst_req),
    .irq      (irq),
    .ctrl_q   (ctrl_q),
    .flag_q   (flag_q)
);

// File: tb/wdog_steer_tb.sv
module wdog_steer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       rst_req, irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    wdog_steer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_16hz (tick),
        .bus_wr    (wr),
        .bus_rd    (rd),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .rst_req   (rst_req),
        .irq       (irq)
    );

    // behavioural reference model
    int   m_cnt = 0;
    int   m_ctrl = 0, m_aux = 0;
    bit   m_flag = 0, m_rst = 0, m_irq = 0;

    function automatic int timeout_of(int v);
        return ((v >> 2) & 31) * (1 << (2 * (v & 3)));
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_ctrl = 0; m_aux = 0; m_flag = 0; m_rst = 0; m_irq = 0;
        end else begin
            bit ld, ex;
            ld = (wr && addr == 2'd1) || (rd && addr == 2'd0);
            ex = !ld && tick && m_cnt == 1;
            m_rst = 0; m_irq = 0;
            if (ld) m_cnt = timeout_of((wr && addr == 2'd1) ? int'(wdata) : m_ctrl);
            else if (tick && m_cnt > 0) m_cnt = m_cnt - 1;
            if (wr && addr == 2'd1) begin m_ctrl = wdata; m_flag = 0; end
            if (wr && addr == 2'd2) m_aux = wdata;
            if (ex) begin
                m_flag = 1;
                if (m_ctrl[7]) begin
                    m_ctrl = 0; m_aux = m_aux & 8'hBF; m_rst = 1;
                end else m_irq = 1;
            end
        end
    end

    function automatic int model_rdata(logic [1:0] a);
        case (a)
            2'd0: return m_flag ? 8'h80 : 8'h00;
            2'd1: return m_ctrl;
            2'd2: return m_aux;
            default: return 0;
        endcase
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R6", "rst_req vs model", int'(rst_req), int'(m_rst));
            check("R7", "irq vs model", int'(irq), int'(m_irq));
            check("R10", "rdata vs model", int'(rdata), model_rdata(addr));
        end
    end

    task automatic wr_reg(logic [1:0] a, logic [7:0] d);
        @(negedge clk); #1; wr = 1; rd = 0; addr = a; wdata = d; tick = 0;
        @(negedge clk); #1; wr = 0;
    endtask

    task automatic rd_reg(logic [1:0] a, output logic [7:0] v);
        @(negedge clk); #1; rd = 1; wr = 0; addr = a; tick = 0;
        #1; v = rdata;
        @(negedge clk); #1; rd = 0;
    endtask

    task automatic run(int n, output int nr, output int ni, output int first);
        nr = 0; ni = 0; first = 0;
        for (int i = 1; i <= n; i++) begin
            tick = 1;
            @(negedge clk);
            if (rst_req) nr++;
            if (irq) ni++;
            if (first == 0 && (rst_req || irq)) first = i;
            #1;
        end
        tick = 0;
    endtask

    initial begin
        #2_000_000;
        checks++; fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int nr, ni, first;
        repeat (3) @(negedge clk);
        #1; rst_n = 1;
        // R1 reset state
        rd_reg(2'd0, v); check("R1", "flags after reset", v, 8'h00);
        rd_reg(2'd1, v); check("R1", "ctrl after reset", v, 8'h00);
        rd_reg(2'd2, v); check("R1", "aux after reset", v, 8'h00);
        check("R1", "pulses after reset", int'(rst_req | irq), 0);
        // R10 map, R9 read-only flags
        wr_reg(2'd2, 8'h5A); rd_reg(2'd2, v); check("R10", "aux readback", v, 8'h5A);
        wr_reg(2'd0, 8'hFF); rd_reg(2'd0, v); check("R9", "flags ignore write", v, 8'h00);
        wr_reg(2'd3, 8'hFF); rd_reg(2'd3, v); check("R10", "addr3 reads zero", v, 8'h00);
        // R2, R7: mult 3, exponent 1 -> 12 ticks, interrupt mode
        wr_reg(2'd1, 8'h0D);
        run(60, nr, ni, first);
        check("R2", "ticks to irq (12)", first, 12);
        check("R7", "irq cycles", ni, 1);
        check("R7", "no reset in irq mode", nr, 0);
        rd_reg(2'd1, v); check("R7", "ctrl kept", v, 8'h0D);
        rd_reg(2'd0, v); check("R5", "flag set", v, 8'h80);
        // R4: flags read reloads, flag stays
        run(8, nr, ni, first);
        rd_reg(2'd0, v); check("R4", "flag not cleared by read", v, 8'h80);
        run(11, nr, ni, first); check("R4", "reload postponed expiry", ni, 0);
        run(3, nr, ni, first); check("R4", "expiry after reload", first, 1);
        // R3: control write clears flag
        wr_reg(2'd1, 8'h0D);
        rd_reg(2'd0, v); check("R3", "flag cleared by ctrl write", v, 8'h00);
        run(12, nr, ni, first); check("R3", "restart period", first, 12);
        // R6: steered reset, mult 1 exponent 1 -> 4 ticks
        wr_reg(2'd2, 8'hFF);
        wr_reg(2'd1, 8'h85);
        run(20, nr, ni, first);
        check("R6", "ticks to reset (4)", first, 4);
        check("R6", "reset cycles", nr, 1);
        check("R6", "no irq in reset mode", ni, 0);
        rd_reg(2'd1, v); check("R6", "ctrl cleared", v, 8'h00);
        rd_reg(2'd2, v); check("R6", "aux bit6 cleared", v, 8'hBF);
        rd_reg(2'd0, v); check("R5", "flag set on reset expiry", v, 8'h80);
        // R2: mult 1 exponent 3 -> 64 ticks
        wr_reg(2'd1, 8'h07);
        run(80, nr, ni, first); check("R2", "ticks to irq (64)", first, 64);
        // R2: maximum, steered -> 1984 ticks
        wr_reg(2'd1, 8'hFF);
        run(2000, nr, ni, first); check("R2", "ticks to reset (1984)", first, 1984);
        // R8: zero multiplier never expires
        wr_reg(2'd1, 8'h83);
        run(2500, nr, ni, first); check("R8", "no pulse with zero multiplier", nr + ni, 0);
        wr_reg(2'd1, 8'h03);
        rd_reg(2'd0, v);
        run(300, nr, ni, first); check("R8", "no pulse after flags read", nr + ni, 0);
        repeat (2) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule